// File: doc/BRIEF.md
# Timed Serial DAC Write Controller

This block is the host-side master for a 3-wire serial digital-to-analog converter that takes 16-bit codes. A client hands it a code over a valid/ready port. The block then runs one frame on the serial pins: it lowers the active-low select line, clocks the code out most significant bit first, and raises the select line again. Every serial interval is a whole number of system clock cycles, and each one is set by a parameter. The block derives no clock from a free-running divider.

After reset the block holds off all serial activity for a programmable power-up wait. It then applies three separate minimum intervals: select-to-first-clock setup, clock-to-select hold, and a clock high time equal to its low time, which gives an even duty cycle. Serial data changes on the falling clock edge, so the receiver always samples a settled bit on the rising edge. A request made during a frame waits until that frame and the inter-frame gap are over.

With the default 50 MHz system clock, each phase of the serial clock lasts three cycles (60 ns). That gives a serial clock of about 8.3 MHz. The power-up wait of 1000 cycles lasts 20 µs.

Top module: `sdac_writer`

## Requirements
- R1: While rst_ni is low, cs_n_o is 1, sclk_o is 0, sdo_o is 0, ready_o is 0 and busy_o is 0.
- R2: ready_o stays low, and cs_n_o stays high, for at least WAIT_CYC clock cycles after reset is released. ready_o is high no later than WAIT_CYC+3 cycles after release.
- R3: A request is taken in a cycle where valid_i and ready_o are both 1. On the next clock edge cs_n_o goes to 0, busy_o goes to 1 and ready_o goes to 0.
- R4: Each frame carries exactly DATA_W rising edges of sclk_o. The bit on sdo_o at the k-th rising edge is code_i[DATA_W-k], so the most significant bit goes first. The bit changes only together with a falling edge of sclk_o, or with the fall of cs_n_o for the first bit.
- R5: The first rising edge of sclk_o comes exactly SETUP_CYC cycles after cs_n_o falls.
- R6: Every high phase and every low phase of sclk_o inside a frame lasts exactly HALF_CYC cycles.
- R7: cs_n_o rises exactly HOLD_CYC cycles after the last falling edge of sclk_o.
- R8: sclk_o is 0 whenever cs_n_o is 1. Between two frames, cs_n_o stays high for at least GAP_CYC+1 cycles.
- R9: ready_o is 0 while cs_n_o is 0. A request held during a frame is accepted after that frame and sent intact.
- R10: sdo_o does not change while sclk_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request valid |
| code_i | input | DATA_W | Code to send |
| ready_o | output | 1 | Block can take a request |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| cs_n_o | output | 1 | Serial select, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| sdo_o | output | 1 | Serial data, MSB first |

## Verification
Two things can fall in the same cycle: the end of the inter-frame gap and the arrival of a new request that has been pending through the whole previous frame. The bench provokes this by raising a second request while the first frame is still shifting, and by holding valid high during the power-up wait. A passive monitor then measures, at cycle resolution, the select gap, the setup, phase and hold intervals, and the received word of both frames. It also flags any ready pulse seen while select is low, and any change on the data line during a clock high phase.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  typedef enum logic [2:0] {
    ST_PWR,
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_HOLD,
    ST_GAP
  } sdac_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sdac_holdoff.sv
module sdac_holdoff #(
  parameter int CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (cnt_q != LIMIT)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIMIT);

  assert_done_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/sdac_interval.sv
module sdac_interval #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdac_shreg.sv
module sdac_shreg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] data_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (load_i)   sr_q <= data_i;
    else if (shift_i)  sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];

  assert_load_shift_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));
endmodule

// File: rtl/sdac_writer.sv
module sdac_writer
  import sdac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int WAIT_CYC  = 1000,
  parameter int SETUP_CYC = 3,
  parameter int HALF_CYC  = 3,
  parameter int HOLD_CYC  = 3,
  parameter int GAP_CYC   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] code_i,
  output logic              ready_o,
  output logic              busy_o,
  output logic              cs_n_o,
  output logic              sclk_o,
  output logic              sdo_o
);
  localparam int MAX_C = max4(SETUP_CYC, HALF_CYC, HOLD_CYC, GAP_CYC);
  localparam int TW    = $clog2(MAX_C + 1);
  localparam int BW    = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
  localparam logic [TW-1:0] T_HALF  = TW'(HALF_CYC - 1);
  localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
  localparam logic [TW-1:0] T_GAP   = TW'(GAP_CYC - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  sdac_state_e   state_q, state_d;
  logic          cs_q, cs_d, sclk_q, sclk_d;
  logic [BW-1:0] bit_q, bit_d;
  logic          pwr_done, tmr_zero, tmr_load, sh_load, sh_shift;
  logic [TW-1:0] tmr_val;

  sdac_holdoff #(.CYC(WAIT_CYC)) u_holdoff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_o (pwr_done)
  );

  sdac_interval #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  sdac_shreg #(.W(DATA_W)) u_shreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (sh_load),
    .shift_i (sh_shift),
    .data_i  (code_i),
    .msb_o   (sdo_o)
  );

  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    bit_d    = bit_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    unique case (state_q)
      ST_PWR:   if (pwr_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (valid_i) begin
          sh_load  = 1'b1;
          cs_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = T_SETUP;
          state_d  = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          bit_d    = LAST_BIT;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
          state_d  = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (tmr_zero) begin
          sclk_d   = 1'b0;
          tmr_load = 1'b1;
          if (bit_q == '0) begin
            tmr_val = T_HOLD;
            state_d = ST_HOLD;
          end else begin
            // next bit changes with the falling edge
            sh_shift = 1'b1;
            bit_d    = bit_q - 1'b1;
            tmr_val  = T_HALF;
            state_d  = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_HALF;
          state_d  = ST_HIGH;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          cs_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = T_GAP;
          state_d  = ST_GAP;
        end
      end
      ST_GAP:   if (tmr_zero) state_d = ST_IDLE;
      default:  state_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b0;
      bit_q   <= '0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      bit_q   <= bit_d;
    end
  end

  assign cs_n_o  = cs_q;
  assign sclk_o  = sclk_q;
  assign ready_o = (state_q == ST_IDLE);
  assign busy_o  = (state_q != ST_IDLE) && (state_q != ST_PWR);

  assert_no_frame_in_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_done |-> cs_n_o);

  assert_cs_fall_on_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_n_o) |-> $past(valid_i && ready_o));

  assert_idle_clk_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o);

  assert_no_ready_in_frame_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_n_o |-> !ready_o);

  assert_data_hold_high_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));
endmodule

// File: tb/sdac_writer_tb.sv
module sdac_writer_tb;
  localparam int DW = 16, WAIT = 1000, SETUP = 3, HALF = 3, HOLD = 3, GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [DW-1:0] code = '0;
  logic ready, busy, cs_n, sclk, sdo;

  always #10 clk = ~clk;

  sdac_writer #(.DATA_W(DW), .WAIT_CYC(WAIT), .SETUP_CYC(SETUP), .HALF_CYC(HALF),
                .HOLD_CYC(HOLD), .GAP_CYC(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .code_i(code), .ready_o(ready),
    .busy_o(busy), .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo));

  int total = 0, bad = 0;

  // passive monitor, sampled on falling system clock edge
  int cyc = 0, t_cs_fall = 0, t_cs_rise = -1000, t_rise = 0, t_fall = 0, t_first = 0;
  int rises = 0, min_hi, max_hi, min_lo, max_lo, last_gap = 1000, frames = 0;
  int hold_viol = 0, ready_in_frame = 0, idle_clk = 0, rel_cyc = 0;
  logic [DW-1:0] rx = '0;
  logic [DW-1:0] words [0:63];
  logic p_cs = 1'b1, p_sclk = 1'b0, p_sdo = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (p_cs && !cs_n) begin
      last_gap = cyc - t_cs_rise; t_cs_fall = cyc; rises = 0; rx = '0;
      min_hi = 1 << 20; max_hi = 0; min_lo = 1 << 20; max_lo = 0;
    end
    if (!p_sclk && sclk) begin
      if (rises == 0) t_first = cyc;
      else begin
        if (cyc - t_fall < min_lo) min_lo = cyc - t_fall;
        if (cyc - t_fall > max_lo) max_lo = cyc - t_fall;
      end
      rises++; rx = {rx[DW-2:0], sdo}; t_rise = cyc;
    end
    if (p_sclk && !sclk) begin
      if (cyc - t_rise < min_hi) min_hi = cyc - t_rise;
      if (cyc - t_rise > max_hi) max_hi = cyc - t_rise;
      t_fall = cyc;
    end
    if (p_sclk && sclk && sdo != p_sdo) hold_viol++;
    if (!cs_n && ready) ready_in_frame++;
    if (cs_n && sclk) idle_clk++;
    if (!p_cs && cs_n) begin
      t_cs_rise = cyc; words[frames % 64] = rx; frames++;
    end
    p_cs = cs_n; p_sclk = sclk; p_sdo = sdo;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [DW-1:0] c);
    @(negedge clk);
    valid = 1'b1; code = c;
    forever begin
      if (ready) begin
        @(negedge clk);
        valid = 1'b0;
        chk(cs_n == 1'b0 && busy && !ready, "R3 accept", {cs_n, busy, ready}, 3'b010);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic check_frame(input int idx, input logic [DW-1:0] c);
    wait (frames > idx);
    @(negedge clk);
    chk(words[idx % 64] == c, "R4 word", words[idx % 64], c);
    chk(rises == DW, "R4 rise count", rises, DW);
    chk(t_first - t_cs_fall == SETUP, "R5 setup", t_first - t_cs_fall, SETUP);
    chk(min_hi == HALF && max_hi == HALF, "R6 high phase", max_hi, HALF);
    chk(min_lo == HALF && max_lo == HALF, "R6 low phase", max_lo, HALF);
    chk(t_cs_rise - t_fall == HOLD, "R7 hold", t_cs_rise - t_fall, HOLD);
    chk(hold_viol == 0, "R10 data hold", hold_viol, 0);
    chk(idle_clk == 0, "R8 idle clock", idle_clk, 0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !sdo && !ready && !busy, "R1 reset outputs",
        {cs_n, sclk, sdo, ready, busy}, 5'b10000);
  endtask

  // request held high across the power-up wait
  task automatic t_powerup;
    int n;
    valid = 1'b1; code = 16'hA5C3;
    rel_cyc = cyc;
    rst_n = 1'b1;
    n = 0;
    while (!ready && n < WAIT + 10) begin
      @(negedge clk); n++;
    end
    chk(n >= WAIT && n <= WAIT + 3, "R2 wait length", n, WAIT);
    chk(frames == 0 && cs_n, "R2 no early frame", frames, 0);
    @(negedge clk);
    valid = 1'b0;
    chk(!cs_n && busy, "R3 pending accept", cs_n, 0);
    check_frame(0, 16'hA5C3);
  endtask

  task automatic t_single(input logic [DW-1:0] c);
    int idx;
    idx = frames;
    send(c);
    check_frame(idx, c);
  endtask

  task automatic t_back_to_back(input logic [DW-1:0] a, input logic [DW-1:0] b);
    int idx, rdy0;
    idx = frames; rdy0 = ready_in_frame;
    send(a);
    send(b);
    check_frame(idx + 1, b);
    chk(words[idx % 64] == a, "R9 first word", words[idx % 64], a);
    chk(last_gap >= GAP + 1, "R8 select gap", last_gap, GAP + 1);
    chk(ready_in_frame == rdy0, "R9 ready in frame", ready_in_frame - rdy0, 0);
  endtask

  initial begin
    t_reset();
    t_powerup();
    t_single(16'h0000);
    t_single(16'hFFFF);
    t_single(16'h8000);
    t_single(16'h0001);
    t_back_to_back(16'h5A3C, 16'hC001);
    t_back_to_back(16'h7FFE, 16'h1234);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule